// File: doc/BRIEF.md
# Drive-Status Serial Transmitter

This block is the sending side of a slow four-wire status link that reports the state of eight storage drives to an external decoder. It divides the system clock down to a serial clock near 32 kHz and sends a continuous series of fixed-length streams. A load line marks where each stream begins and then carries a short vendor pattern. Two data lines each carry one status set per stream, covering the drives in a fixed order.

Each drive contributes three bits per data line: activity, then locate, then fault. This gives a 24-bit stream on each line. All four lines are open-drain. The block only ever pulls a line low or lets it go, and a pull-up outside the block provides the high level. The status vectors and the pattern are captured once at the start of each stream, so software can rewrite them at any time without tearing a frame. Dropping the enable releases every line and restarts the rotation at drive 0.

Top module: `sgp_tx`

## Requirements
- R1: While reset is high or `en` is low, all four pull outputs are 0, so every line is released high, the serial clock rests high and no serial-clock falling edge occurs.
- R2: While enabled, the serial clock line has a period of 2*HALF system cycles, with HALF = SYS_HZ/(2*SCLK_HZ) (minimum 2), and it stays high for exactly HALF cycles before each fall.
- R3: The load and data lines change only in the system cycle where the serial clock rises, so they hold the same value from each rise through the following fall.
- R4: A stream is DRIVES*BITS_PER_DRIVE = 24 serial-clock cycles long, and the load line is high during bit 0 of every stream.
- R5: During stream bits 1 to 4 the load line carries `vend_pat` with its most significant bit first. It is low for bits 5 to 23.
- R6: On data line A, stream bit k equals `stat_a[k]`. Drive d occupies bits 3d (activity), 3d+1 (locate) and 3d+2 (fault), so drives are sent 0 through 7, and the next stream starts again at drive 0.
- R7: Data line B carries `stat_b` with the same bit mapping as R6, independently of line A.
- R8: `stat_a`, `stat_b` and `vend_pat` are sampled at the serial-clock rise that starts a stream. A change made later only appears in the next stream.
- R9: A pull output at 1 drives its line low (logic 0). A pull output at 0 releases the line (logic 1).
- R10: Dropping `en` in the middle of a stream releases all lines on the next system cycle. After `en` returns, a new stream starts from drive 0 and pattern bit 0.
- R11: After `en` rises, the first serial-clock fall sees all lines released, and bit 0 of the first stream is presented at the first serial-clock rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Runs the link when high |
| stat_a | input | DRIVES*BITS_PER_DRIVE | Status bits for data line A, three per drive |
| stat_b | input | DRIVES*BITS_PER_DRIVE | Status bits for data line B, three per drive |
| vend_pat | input | PAT_W | Vendor pattern sent on the load line after its start marker |
| sclk_pull | output | 1 | Pulls the serial clock line low when 1 |
| load_pull | output | 1 | Pulls the load line low when 1 |
| dout_a_pull | output | 1 | Pulls data line A low when 1 |
| dout_b_pull | output | 1 | Pulls data line B low when 1 |

## Verification
The bench builds the block with SYS_HZ = 256000 and SCLK_HZ = 32000, which gives a half period of four system cycles. A whole 24-bit stream therefore takes 192 cycles. At that speed a short run covers several back-to-back streams, input changes placed in the middle of the pattern and of the status bits, and a disable in the middle of a stream followed by a restart. The drive count, bits per drive and pattern width stay at their defaults, so the exact drive rotation and three-bit ordering are observed on the lines at every serial-clock fall.

// File: rtl/sgp_pkg.sv
package sgp_pkg;

  // number of independent serial data lines
  localparam int unsigned SGP_LANES = 2;

  // half period of the serial clock in system cycles, never below 2
  function automatic int unsigned sgp_half_div(input int unsigned sys_hz,
                                               input int unsigned sclk_hz);
    int unsigned h;
    h = sys_hz / (2 * sclk_hz);
    return (h < 2) ? 2 : h;
  endfunction

endpackage

// File: rtl/sgp_clk_div.sv
module sgp_clk_div #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic sclk_pull_o,
  output logic rise_stb_o
);

  localparam int unsigned   CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] TERM = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          term;

  assign term = (cnt_q == TERM);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q       <= '0;
      sclk_pull_o <= 1'b0;
    end else if (term) begin
      cnt_q       <= '0;
      sclk_pull_o <= ~sclk_pull_o;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // the line goes high in the cycle after this strobe; data moves on the same edge
  assign rise_stb_o = en && term && sclk_pull_o;

  // R1: a disabled link leaves the clock line released
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sclk_pull_o);

  // R2: the clock line only toggles at the end of a half period
  assert_half_period_R2: assert property (@(posedge clk) disable iff (rst)
    (en && !term) |=> (!en || $stable(sclk_pull_o)));

endmodule

// File: rtl/sgp_framer.sv
module sgp_framer #(
  parameter int unsigned STREAM_W = 24,
  parameter int unsigned PAT_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             rise_stb_i,
  input  logic [PAT_W-1:0] pat_i,
  output logic             start_stb_o,
  output logic             load_pull_o
);

  localparam int unsigned   IW   = $clog2(STREAM_W);
  localparam logic [IW-1:0] LAST = IW'(STREAM_W - 1);

  logic [IW-1:0]    idx_q;
  logic [IW-1:0]    idx_nx;
  logic             started_q;
  logic [PAT_W-1:0] pat_q;
  logic             load_lvl;

  always_comb begin
    start_stb_o = rise_stb_i && (!started_q || idx_q == LAST);
    idx_nx      = start_stb_o ? '0 : idx_q + IW'(1);
    load_lvl    = (idx_nx == '0);
    // pattern bits follow the marker, most significant first
    for (int j = 0; j < int'(PAT_W); j++) begin
      if (int'(idx_nx) == int'(PAT_W) - j) load_lvl = pat_q[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      idx_q       <= '0;
      started_q   <= 1'b0;
      pat_q       <= '0;
      load_pull_o <= 1'b0;
    end else if (rise_stb_i) begin
      idx_q       <= idx_nx;
      started_q   <= 1'b1;
      load_pull_o <= ~load_lvl;
      if (start_stb_o) pat_q <= pat_i;
    end
  end

  // R4: the bit index never leaves the stream
  assert_index_bound_R4: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST);

  // R4: every stream opens with the load line released (high)
  assert_marker_high_R4: assert property (@(posedge clk) disable iff (rst)
    start_stb_o |=> !load_pull_o);

  // R5: after the pattern the load line is held low until the stream ends
  assert_load_low_after_pat_R5: assert property (@(posedge clk) disable iff (rst)
    (rise_stb_i && started_q && int'(idx_q) >= int'(PAT_W) && idx_q != LAST)
      |=> load_pull_o);

endmodule

// File: rtl/sgp_lane.sv
module sgp_lane #(
  parameter int unsigned STREAM_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                rise_stb_i,
  input  logic                start_stb_i,
  input  logic [STREAM_W-1:0] stat_i,
  output logic                pull_o
);

  // shadow of the bits still to be sent in this stream
  logic [STREAM_W-2:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sh_q   <= '0;
      pull_o <= 1'b0;
    end else if (start_stb_i) begin
      pull_o <= ~stat_i[0];
      sh_q   <= stat_i[STREAM_W-1:1];
    end else if (rise_stb_i) begin
      pull_o <= ~sh_q[0];
      sh_q   <= {1'b0, sh_q[STREAM_W-2:1]};
    end
  end

  // R3: the line holds between serial-clock rises
  assert_hold_between_rises_R3: assert property (@(posedge clk) disable iff (rst)
    (en && !rise_stb_i) |=> (!en || $stable(pull_o)));

  // R6 / R9: the first bit of a stream is status bit 0, pulled low when it is 0
  assert_first_bit_R6: assert property (@(posedge clk) disable iff (rst)
    start_stb_i |=> (pull_o == !$past(stat_i[0])));

endmodule

// File: rtl/sgp_tx.sv
module sgp_tx
  import sgp_pkg::*;
#(
  parameter int unsigned SYS_HZ         = 25_000_000,
  parameter int unsigned SCLK_HZ        = 32_000,
  parameter int unsigned DRIVES         = 8,
  parameter int unsigned BITS_PER_DRIVE = 3,
  parameter int unsigned PAT_W          = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             en,
  input  logic [DRIVES*BITS_PER_DRIVE-1:0] stat_a,
  input  logic [DRIVES*BITS_PER_DRIVE-1:0] stat_b,
  input  logic [PAT_W-1:0]                 vend_pat,
  output logic                             sclk_pull,
  output logic                             load_pull,
  output logic                             dout_a_pull,
  output logic                             dout_b_pull
);

  localparam int unsigned STREAM_W = DRIVES * BITS_PER_DRIVE;
  localparam int unsigned HALF     = sgp_half_div(SYS_HZ, SCLK_HZ);

  logic                                rise_stb;
  logic                                start_stb;
  logic [SGP_LANES-1:0][STREAM_W-1:0]  lane_stat;
  logic [SGP_LANES-1:0]                lane_pull;

  assign lane_stat[0] = stat_a;
  assign lane_stat[1] = stat_b;

  sgp_clk_div #(.HALF(HALF)) u_clk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .sclk_pull_o(sclk_pull),
    .rise_stb_o (rise_stb)
  );

  sgp_framer #(.STREAM_W(STREAM_W), .PAT_W(PAT_W)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .rise_stb_i (rise_stb),
    .pat_i      (vend_pat),
    .start_stb_o(start_stb),
    .load_pull_o(load_pull)
  );

  for (genvar g = 0; g < SGP_LANES; g++) begin : g_lane
    sgp_lane #(.STREAM_W(STREAM_W)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .en         (en),
      .rise_stb_i (rise_stb),
      .start_stb_i(start_stb),
      .stat_i     (lane_stat[g]),
      .pull_o     (lane_pull[g])
    );
  end

  assign dout_a_pull = lane_pull[0];
  assign dout_b_pull = lane_pull[1];

  // R3: nothing moves on the edge where the serial clock falls
  assert_stable_at_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_pull) |-> ($stable(load_pull) && $stable(dout_a_pull) && $stable(dout_b_pull)));

  // R1 / R10: dropping the enable releases every line on the next cycle
  assert_release_when_off_R1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!load_pull && !dout_a_pull && !dout_b_pull));

endmodule

// File: tb/sgp_tx_test.sv
module sgp_tx_test;

  localparam int CLK_PERIOD = 10;
  localparam int SYS_HZ     = 256000;
  localparam int SCLK_HZ    = 32000;
  localparam int HALF       = 4;
  localparam int SW         = 24;
  localparam int PW         = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en  = 1'b0;
  logic [SW-1:0] stat_a = '0;
  logic [SW-1:0] stat_b = '0;
  logic [PW-1:0] vend_pat = '0;
  logic          sclk_pull, load_pull, dout_a_pull, dout_b_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgp_tx #(.SYS_HZ(SYS_HZ), .SCLK_HZ(SCLK_HZ), .DRIVES(8), .BITS_PER_DRIVE(3), .PAT_W(PW)) uut (
    .clk(clk), .rst(rst), .en(en), .stat_a(stat_a), .stat_b(stat_b), .vend_pat(vend_pat),
    .sclk_pull(sclk_pull), .load_pull(load_pull), .dout_a_pull(dout_a_pull), .dout_b_pull(dout_b_pull)
  );

  typedef struct {
    logic  ld; logic da; logic db;
    string tl; string ta; string tb;
  } exp_t;

  exp_t expq[$];
  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int n_falls = 0;
  bit fall_ok = 0;
  bit rise_ok = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check_bit(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic check_int(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver side of the scoreboard: one item per expected serial-clock fall
  task automatic push_idle();
    exp_t e;
    e.ld = 1'b1; e.da = 1'b1; e.db = 1'b1;
    e.tl = "R11"; e.ta = "R11"; e.tb = "R11";
    expq.push_back(e);
  endtask

  task automatic push_stream(logic [SW-1:0] a, logic [SW-1:0] b, logic [PW-1:0] p, string note);
    for (int k = 0; k < SW; k++) begin
      exp_t e;
      e.ld = (k == 0) ? 1'b1 : ((k <= PW) ? p[PW-k] : 1'b0);
      e.da = a[k];
      e.db = b[k];
      e.tl = (k == 0) ? {"R4", note} : {"R5", note};
      e.ta = {"R6 R9", note};
      e.tb = {"R7 R9", note};
      expq.push_back(e);
    end
  endtask

  task automatic check_released(string tag);
    check_bit(tag, ~sclk_pull,   1'b1, "serial clock line released");
    check_bit(tag, ~load_pull,   1'b1, "load line released");
    check_bit(tag, ~dout_a_pull, 1'b1, "data line A released");
    check_bit(tag, ~dout_b_pull, 1'b1, "data line B released");
  endtask

  // monitor side: sample line levels at each serial-clock fall
  logic p_s = 1'b1;
  logic r_l = 1'b1, r_a = 1'b1, r_b = 1'b1;
  int   last_fall = 0, last_rise = 0;

  always @(negedge clk) begin
    logic s, l, a, b;
    exp_t e;
    s = ~sclk_pull; l = ~load_pull; a = ~dout_a_pull; b = ~dout_b_pull;
    if (!rst) begin
      if (p_s && !s) begin
        n_falls++;
        if (rise_ok) begin
          check_bit("R3", l, r_l, "load held from rise to fall");
          check_bit("R3", a, r_a, "data A held from rise to fall");
          check_bit("R3", b, r_b, "data B held from rise to fall");
          check_int("R2", cyc - last_rise, HALF, "high phase length");
        end
        if (fall_ok) check_int("R2", cyc - last_fall, 2*HALF, "serial clock period");
        last_fall = cyc;
        fall_ok = 1;
        if (expq.size() > 0) begin
          e = expq.pop_front();
          check_bit(e.tl, l, e.ld, "load line");
          check_bit(e.ta, a, e.da, "data line A");
          check_bit(e.tb, b, e.db, "data line B");
        end
      end else if (!p_s && s) begin
        last_rise = cyc;
        rise_ok = 1;
        r_l = l; r_a = a; r_b = b;
      end
    end
    p_s = s;
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired, run did not complete");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    check_released("R1");          // during reset
    rst = 1'b0;
    repeat (20) @(negedge clk);
    check_released("R1");          // out of reset but disabled
    check_int("R1", n_falls, 0, "no serial clock falls while disabled");

    // stream A, then inputs rewritten mid-pattern for stream B (R8)
    stat_a = 24'b110_001_011_100_000_101_010_111;
    stat_b = 24'b001_110_100_011_111_010_101_000;
    vend_pat = 4'b1011;
    push_idle();
    push_stream(stat_a, stat_b, vend_pat, " stream A");
    en = 1'b1;
    repeat (28) @(negedge clk);
    stat_a = 24'h5A_C3_0F;
    stat_b = 24'hF0_3C_A5;
    vend_pat = 4'b0110;
    push_stream(stat_a, stat_b, vend_pat, " R8 stream B");
    repeat (200) @(negedge clk);
    stat_a = 24'h80_00_01;
    stat_b = 24'h7F_FF_FE;
    vend_pat = 4'b1100;
    push_stream(stat_a, stat_b, vend_pat, " R8 stream C");

    // drop enable in the middle of stream C (R10)
    while (expq.size() != 10) @(posedge clk);
    @(negedge clk);
    en = 1'b0;
    expq.delete();
    @(negedge clk);
    check_released("R10");
    repeat (3) @(negedge clk);
    @(posedge clk);
    fall_ok = 0;
    rise_ok = 0;

    // restart must begin at drive 0 with a fresh marker
    stat_a = 24'b011_101_110_000_111_001_100_010;
    stat_b = 24'b100_010_001_111_000_110_011_101;
    vend_pat = 4'b1001;
    push_idle();
    push_stream(stat_a, stat_b, vend_pat, " R10 restart");
    @(negedge clk);
    en = 1'b1;
    while (expq.size() != 0) @(posedge clk);
    repeat (2) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check_released("R1");
    check_int("R6", expq.size(), 0, "all expected stream bits observed");
    finish_run();
  end

endmodule